// File: doc/BRIEF.md
# Parallel ROM Read Cycle Controller

This block runs read cycles on an external asynchronous parallel ROM with a 14-bit address, an 8-bit data bus, and active-low chip-enable and output-enable pins. A host offers a request with an address. When the controller is idle it accepts the request. It drives the address and chip enable low on the same edge, and drops output enable at the latest edge that still meets the output-enable delay. It then waits until the address, chip-enable and output-enable delays have all run out, captures the byte, and returns it with a one-cycle valid flag.

Each of the four analog delays is a parameter given in nanoseconds: address access, chip-enable access, output-enable access and output float. The controller turns each one into a clock count by rounding up against the clock-period parameter. After a read it keeps the ROM deselected for the float time, so the next driver never meets a bus that is still being driven. Between reads the ROM sits in standby with chip enable high.

The controller has four named states:
- `S_IDLE` waits for a request. The ROM is deselected.
- `S_LEAD` has chip enable low and output enable still high.
- `S_OEWAIT` has both enables low and waits for the data.
- `S_FLOAT` is the recovery gap after release.

The transitions are:
- `S_IDLE`→`S_LEAD` on accept, when there is a lead time.
- `S_IDLE`→`S_OEWAIT` on accept, when there is no lead time.
- `S_LEAD`→`S_OEWAIT` when the lead count expires.
- `S_OEWAIT`→`S_FLOAT` at the sampling edge.
- `S_FLOAT`→`S_IDLE` when the float count expires.

Top module: `romrd_ctrl`

## Requirements
- R1: While reset is held and directly after it, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only on an edge where `req_ready` is 1. A `req_valid` offered while `req_ready` is 0 starts no cycle and does not change `rom_addr`.
- R3: On the accept edge, `rom_addr` takes `req_addr` and `rom_ce_n` goes to 0. `rom_addr` holds steady for as long as `rom_ce_n` stays 0.
- R4: Each delay becomes a cycle count equal to ceil(delay_ns / CLK_NS), with a minimum of 1. With the defaults (20 ns clock; 45, 45, 25 and 25 ns) the counts are 3, 3, 2 and 2.
- R5: `rom_oe_n` goes to 0 exactly LEAD cycles after the accept edge. LEAD = max(address count, chip-enable count) − output-enable count, or 0 if that difference is negative.
- R6: The byte on `rom_data` is captured at the edge where all three access counts have expired. This edge is max(address, chip-enable, output-enable counts) cycles after the accept edge. `rsp_valid` is 1 after that edge, for exactly one cycle, with `rsp_data` equal to the captured byte.
- R7: On the capture edge, `rom_ce_n` and `rom_oe_n` both return to 1.
- R8: After release, `rom_ce_n` stays 1 for at least the float count. If a request is already waiting, `rom_ce_n` falls again exactly float count + 1 cycles after it rose.
- R9: `rom_oe_n` is never 0 while `rom_ce_n` is 1, and the ROM stays deselected while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | High when a request can be accepted (idle) |
| req_addr | input | 14 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse: read byte is valid |
| rsp_data | output | 8 | Byte read from the ROM |
| rom_addr | output | 14 | Address pins to the ROM |
| rom_ce_n | output | 1 | Chip enable to the ROM, active low |
| rom_oe_n | output | 1 | Output enable to the ROM, active low |
| rom_data | input | 8 | Data pins from the ROM |

## Verification
The bench builds the block with its defaults: a 20 ns clock, 45 ns for address and chip-enable access, and 25 ns for output enable and float. These give counts of 3, 3, 2 and 2, so there is a nonzero lead of one cycle between chip enable and output enable. The bench's ROM model returns the inverse of the true byte until its own age counters show that every delay has been met. Any early capture is therefore visible.

With these values, a sweep over all 16384 addresses fits inside the run limit. On every read the bench checks the lead, the latency, the pulse width and the release. Separate runs cover back-to-back requests, to measure the float gap, and requests offered while the controller is busy.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LEAD   = 2'd1,
        S_OEWAIT = 2'd2,
        S_FLOAT  = 2'd3
    } romrd_state_e;

    // Round a delay up to whole clock periods, never below one cycle.
    function automatic int ns_to_cyc(input int delay_ns, input int clk_ns);
        int c;
        c = (delay_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/romrd_timer.sv
module romrd_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/romrd_fsm.sv
module romrd_fsm
    import romrd_pkg::*;
#(
    parameter int AW      = 14,
    parameter int DW      = 8,
    parameter int TW      = 3,
    parameter int LEAD_C  = 1,
    parameter int OE_C    = 2,
    parameter int FLT_C   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    input  logic [DW-1:0] rom_data,
    input  logic          t_expired,
    output logic          t_load,
    output logic [TW-1:0] t_val
);
    romrd_state_e st, nxt;
    logic accept;

    assign req_ready = (st == S_IDLE);
    assign accept    = req_ready && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Next state and timer loads
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            S_IDLE: if (accept) begin
                t_load = 1'b1;
                if (LEAD_C > 0) begin
                    nxt   = S_LEAD;
                    t_val = TW'(LEAD_C - 1);
                end else begin
                    nxt   = S_OEWAIT;
                    t_val = TW'(OE_C - 1);
                end
            end
            S_LEAD: if (t_expired) begin
                nxt    = S_OEWAIT;
                t_load = 1'b1;
                t_val  = TW'(OE_C - 1);
            end
            S_OEWAIT: if (t_expired) begin
                nxt    = S_FLOAT;
                t_load = 1'b1;
                t_val  = TW'(FLT_C - 1);
            end
            S_FLOAT: if (t_expired) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Registered pin and response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_addr  <= '0;
            rom_ce_n  <= 1'b1;
            rom_oe_n  <= 1'b1;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                S_IDLE: if (accept) begin
                    rom_addr <= req_addr;
                    rom_ce_n <= 1'b0;
                    rom_oe_n <= (LEAD_C > 0);
                end
                S_LEAD: if (t_expired) rom_oe_n <= 1'b0;
                S_OEWAIT: if (t_expired) begin
                    rsp_data  <= rom_data;
                    rsp_valid <= 1'b1;
                    rom_ce_n  <= 1'b1;
                    rom_oe_n  <= 1'b1;
                end
                S_FLOAT: ;
                default: ;
            endcase
        end
    end

    // R9
    oe_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> rom_oe_n);
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> ($rose(rom_ce_n) && rom_oe_n));
    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> $past(req_ready && req_valid));
endmodule

// File: rtl/romrd_ctrl.sv
module romrd_ctrl
    import romrd_pkg::*;
#(
    parameter int AW       = 14,
    parameter int DW       = 8,
    parameter int CLK_NS   = 20,
    parameter int ACC_NS   = 45,
    parameter int CE_NS    = 45,
    parameter int OE_NS    = 25,
    parameter int FLOAT_NS = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    input  logic [DW-1:0] rom_data
);
    // R4: delays rounded up to clock counts
    localparam int ACC_C  = ns_to_cyc(ACC_NS, CLK_NS);
    localparam int CE_C   = ns_to_cyc(CE_NS, CLK_NS);
    localparam int OE_C   = ns_to_cyc(OE_NS, CLK_NS);
    localparam int FLT_C  = ns_to_cyc(FLOAT_NS, CLK_NS);
    localparam int DATA_C = imax(ACC_C, CE_C);
    localparam int LEAD_C = (DATA_C > OE_C) ? DATA_C - OE_C : 0;
    localparam int MAX_C  = imax(imax(LEAD_C, OE_C), FLT_C);
    localparam int TW     = imax($clog2(MAX_C + 1), 1);

    logic          t_load, t_expired;
    logic [TW-1:0] t_val;

    romrd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    romrd_fsm #(
        .AW(AW), .DW(DW), .TW(TW),
        .LEAD_C(LEAD_C), .OE_C(OE_C), .FLT_C(FLT_C)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rom_addr  (rom_addr),
        .rom_ce_n  (rom_ce_n),
        .rom_oe_n  (rom_oe_n),
        .rom_data  (rom_data),
        .t_expired (t_expired),
        .t_load    (t_load),
        .t_val     (t_val)
    );
endmodule

// File: tb/romrd_ctrl_bench.sv
module romrd_ctrl_bench;
    localparam int AW = 14, DW = 8;
    localparam int CLK_NS = 20;
    localparam int ACC_N = (45 + CLK_NS - 1) / CLK_NS;   // 3
    localparam int CE_N  = (45 + CLK_NS - 1) / CLK_NS;   // 3
    localparam int OE_N  = (25 + CLK_NS - 1) / CLK_NS;   // 2
    localparam int FLT_N = (25 + CLK_NS - 1) / CLK_NS;   // 2
    localparam int DAT_N = (ACC_N > CE_N) ? ACC_N : CE_N;
    localparam int LEAD  = (DAT_N > OE_N) ? DAT_N - OE_N : 0;
    localparam int LAT   = (DAT_N > OE_N) ? DAT_N : OE_N;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_data, rom_data;
    logic [AW-1:0] rom_addr;
    logic rom_ce_n, rom_oe_n;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    romrd_ctrl u_romrd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_data(rom_data)
    );

    function automatic logic [DW-1:0] content(input logic [AW-1:0] a);
        return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h3C;
    endfunction

    // ROM model: ages in clock periods since each pin last changed
    int a_age = 0, ce_age = 0, oe_age = 0;
    logic [AW-1:0] p_addr = '0;
    logic p_ce = 1'b1, p_oe = 1'b1;
    always @(negedge clk) begin
        a_age  <= (rom_addr === p_addr) ? a_age + 1 : 0;
        ce_age <= (rom_ce_n === p_ce) ? ce_age + 1 : 0;
        oe_age <= (rom_oe_n === p_oe) ? oe_age + 1 : 0;
        p_addr <= rom_addr;
        p_ce   <= rom_ce_n;
        p_oe   <= rom_oe_n;
    end
    assign rom_data = (!rom_ce_n && !rom_oe_n && a_age >= ACC_N - 1 &&
                       ce_age >= CE_N - 1 && oe_age >= OE_N - 1)
                      ? content(rom_addr) : ~content(rom_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    // One read with full timing checks; returns at the negedge after the pulse
    task automatic do_read(input logic [AW-1:0] a);
        int lat, oe_lat;
        wait_ready();
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rom_ce_n, "R3 ce low after accept", rom_ce_n, 0);
        chk(rom_addr == a, "R3 address driven", rom_addr, a);
        lat = 0; oe_lat = -1;
        while (!rsp_valid && lat < 40) begin
            if (oe_lat < 0 && !rom_oe_n) oe_lat = lat;
            @(negedge clk);
            lat++;
        end
        if (oe_lat < 0 && !rom_oe_n) oe_lat = lat;
        chk(oe_lat == LEAD, "R5 oe lead", oe_lat, LEAD);
        chk(lat == LAT, "R6 latency", lat, LAT);
        chk(rsp_data == content(a), "R6 data", rsp_data, content(a));
        chk(rom_ce_n && rom_oe_n, "R7 release", {rom_ce_n, rom_oe_n}, 3);
        @(negedge clk);
        chk(!rsp_valid, "R6 one-cycle pulse", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rom_ce_n && rom_oe_n && !rsp_valid && req_ready, "R1 in reset",
            {rom_ce_n, rom_oe_n, rsp_valid, req_ready}, 4'b1101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rom_ce_n && rom_oe_n && !rsp_valid && req_ready, "R1 after reset",
            {rom_ce_n, rom_oe_n, rsp_valid, req_ready}, 4'b1101);
        chk(ACC_N == 3 && OE_N == 2 && FLT_N == 2, "R4 rounding", LAT, 3);

        // Sweep every address
        for (int a = 0; a < (1 << AW); a++) do_read(AW'(a));

        // R8: back-to-back requests, measure ce_n high gap
        begin
            int gap;
            wait_ready();
            req_valid = 1'b1; req_addr = 14'h1234;
            while (!rsp_valid) @(negedge clk);
            gap = 0;
            while (rom_ce_n && gap < 40) begin gap++; @(negedge clk); end
            chk(gap == FLT_N + 1, "R8 float gap", gap, FLT_N + 1);
            chk(gap >= FLT_N, "R8 minimum float", gap, FLT_N);
            while (!rsp_valid) @(negedge clk);
            chk(rsp_data == content(14'h1234), "R8 second read data", rsp_data, content(14'h1234));
            req_valid = 1'b0;
            @(negedge clk);
        end

        // R2: request offered while busy is dropped
        begin
            int lows;
            wait_ready();
            req_valid = 1'b1; req_addr = 14'h0ABC;
            @(negedge clk);
            req_addr = 14'h3F00;       // still valid, controller busy
            chk(!req_ready, "R2 busy", req_ready, 0);
            @(negedge clk);
            req_valid = 1'b0;
            chk(rom_addr == 14'h0ABC, "R2 address unchanged", rom_addr, 14'h0ABC);
            while (!rsp_valid) @(negedge clk);
            chk(rsp_data == content(14'h0ABC), "R2 data of accepted read", rsp_data, content(14'h0ABC));
            lows = 0;
            repeat (12) begin
                @(negedge clk);
                if (!rom_ce_n || rsp_valid) lows++;
            end
            chk(lows == 0, "R2 no cycle from busy request", lows, 0);
            chk(rom_oe_n && rom_ce_n, "R9 idle deselected", {rom_ce_n, rom_oe_n}, 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule